// File: doc/BRIEF.md
# Sector-Clamped Four-Leg Inverter Gate Generator

This block produces the eight gate signals of a four-leg inverter whose fourth leg is tied to the load neutral. Each line cycle is divided into six 60-degree sectors. A controller upstream supplies the current sector number together with three duty values: one for the strongest modulated phase leg, one for the weaker modulated phase leg, and one for the neutral leg. In every sector one phase leg is held at a fixed rail. Sectors with even numbers hold the lowest-voltage phase on its lower rail. Sectors with odd numbers hold the highest-voltage phase on its upper rail. The two remaining phase legs and the neutral leg are switched by comparing their duties with a shared sawtooth carrier.

The sector and the three duties are captured only at the end of a carrier period, so a period never mixes two sector patterns. Each leg's upper and lower switches are complementary, with a programmable dead interval in which both are off. A sector code outside 0 to 5 turns every gate off. The nominal duty ordering is dp > dn > dx, but the block does not enforce it.

Top module: `spwm4_top`

## Requirements
- R1: The carrier counts up by one each clock from 0 to 2^CNT_W-1 and then wraps to 0. The period is 2^CNT_W cycles.
- R2: The sector and the three duties are sampled only at the clock edge where the carrier wraps from its maximum to 0. Input changes at any other time have no effect on the gates until the next wrap.
- R3: While the captured sector is 6 or 7, every gate output is 0 and every leg demand is low. After reset, the captured sector reads as 7 until the first wrap.
- R4: The clamped leg is selected by sector as follows (legs 0=A, 1=B, 2=C): sector 0 clamps B, 1 clamps A, 2 clamps C, 3 clamps B, 4 clamps A, 5 clamps C. Even sectors demand the lower switch. Odd sectors demand the upper switch.
- R5: The leg that follows the clamped leg in the cyclic order A->B->C->A demands its upper switch while the carrier is below dp. The third phase leg demands its upper switch while the carrier is below dn. A duty of 0 therefore never demands the upper switch.
- R6: The neutral leg (index 3) demands its upper switch while the carrier is below dx.
- R7: The upper and lower gates of a leg are never both on. After a leg's demand changes, both of its gates stay off for dead_i cycles. When dead_i is 0 there is no gap.
- R8: Each gate reflects the demand computed from the carrier and the captured values one clock earlier.
- R9: While reset is applied, and for two clocks after it is released, all gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| sector_i | input | 3 | 60-degree sector number, 0 to 5 valid |
| duty_p_i | input | CNT_W | Upper-switch duty of the dp leg, in carrier counts |
| duty_n_i | input | CNT_W | Upper-switch duty of the dn leg, in carrier counts |
| duty_x_i | input | CNT_W | Upper-switch duty of the neutral leg, in carrier counts |
| dead_i | input | DT_W | Dead interval in clocks |
| gate_up_o | output | 4 | Upper gates: bit 0 A, 1 B, 2 C, 3 neutral |
| gate_dn_o | output | 4 | Lower gates, same bit order |

## Verification
A gate responds to a carrier position one clock after the carrier holds that position. A new sector or duty becomes visible only after the wrap edge, and then after the one extra clock through the leg stage. After a demand change, a gate is held off for dead_i further clocks. The bench keeps a per-cycle reference of carrier, captured values, leg levels and dead timers, advanced with the same inputs the design samples at each rising edge. It then compares all eight gates at the following falling edge, so every result is checked in exactly the cycle it is due.

// File: rtl/spwm4_pkg.sv
package spwm4_pkg;

  typedef struct packed {
    logic       valid;
    logic       high;
    logic [1:0] clamp;
  } sect_map_t;

  function automatic sect_map_t decode_sector(input logic [2:0] s);
    sect_map_t m;
    m.valid = 1'b1;
    m.high  = s[0];
    case (s)
      3'd0, 3'd3: m.clamp = 2'd1;
      3'd1, 3'd4: m.clamp = 2'd0;
      3'd2, 3'd5: m.clamp = 2'd2;
      default: begin
        m.clamp = 2'd0;
        m.valid = 1'b0;
        m.high  = 1'b0;
      end
    endcase
    return m;
  endfunction

  function automatic logic [1:0] next_leg(input logic [1:0] l);
    return (l == 2'd2) ? 2'd0 : l + 2'd1;
  endfunction

endpackage

// File: rtl/spwm4_carrier.sv
module spwm4_carrier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);

  // R1: carrier advances by one, modulo its period
  p_carrier_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

endmodule

// File: rtl/spwm4_select.sv
module spwm4_select
  import spwm4_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       sector_i,
  input  logic [CNT_W-1:0] dp_i,
  input  logic [CNT_W-1:0] dn_i,
  input  logic [CNT_W-1:0] dx_i,
  output logic [3:0]       demand_o,
  output logic             enable_o
);
  logic [2:0]       sec_q, sec_d;
  logic [CNT_W-1:0] dp_q, dp_d, dn_q, dn_d, dx_q, dx_d;
  sect_map_t        map;
  logic [1:0]       dp_leg, dn_leg;

  always_comb begin
    sec_d = sec_q;
    dp_d  = dp_q;
    dn_d  = dn_q;
    dx_d  = dx_q;
    if (wrap_i) begin
      sec_d = sector_i;
      dp_d  = dp_i;
      dn_d  = dn_i;
      dx_d  = dx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 3'd7;
      dp_q  <= '0;
      dn_q  <= '0;
      dx_q  <= '0;
    end else begin
      sec_q <= sec_d;
      dp_q  <= dp_d;
      dn_q  <= dn_d;
      dx_q  <= dx_d;
    end
  end

  always_comb begin
    map    = decode_sector(sec_q);
    dp_leg = next_leg(map.clamp);
    dn_leg = next_leg(dp_leg);
    demand_o = '0;
    if (map.valid) begin
      for (int i = 0; i < 3; i++) begin
        if (2'(i) == map.clamp)     demand_o[i] = map.high;
        else if (2'(i) == dp_leg)   demand_o[i] = (cnt_i < dp_q);
        else                        demand_o[i] = (cnt_i < dn_q);
      end
      demand_o[3] = (cnt_i < dx_q);
    end
    enable_o = map.valid;
  end

  // R2: captured sector moves only on a carrier wrap
  p_sector_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(sec_q));

  // R4: in a valid sector exactly one phase leg is held at a fixed level
  p_clamp_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o && !wrap_i) |=> (demand_o[map.clamp] == $past(demand_o[map.clamp])));

endmodule

// File: rtl/spwm4_deadtime.sv
module spwm4_deadtime #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            dem_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            up_o,
  output logic            dn_o
);
  logic            lvl_q, lvl_d;
  logic [DT_W-1:0] tmr_q, tmr_d;
  logic            settled;

  always_comb begin
    lvl_d = lvl_q;
    tmr_d = tmr_q;
    if (dem_i != lvl_q) begin
      lvl_d = dem_i;
      tmr_d = '0;
    end else if (tmr_q < dt_i) begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      tmr_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      tmr_q <= tmr_d;
    end
  end

  assign settled = (tmr_q >= dt_i);
  assign up_o    = en_i &  lvl_q & settled;
  assign dn_o    = en_i & ~lvl_q & settled;

  // R7: complementary pair never overlaps
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  // R7: a nonzero dead interval leaves both switches off when the upper one drops
  p_dead_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((dt_i != '0) && $fell(up_o)) |-> !dn_o);

endmodule

// File: rtl/spwm4_top.sv
module spwm4_top #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sector_i,
  input  logic [CNT_W-1:0] duty_p_i,
  input  logic [CNT_W-1:0] duty_n_i,
  input  logic [CNT_W-1:0] duty_x_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [3:0]       gate_up_o,
  output logic [3:0]       gate_dn_o
);
  localparam int N_LEGS = 4;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [N_LEGS-1:0] demand;
  logic             enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spwm4_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  spwm4_select #(.CNT_W(CNT_W)) u_select (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wrap_i   (wrap),
    .cnt_i    (cnt),
    .sector_i (sector_i),
    .dp_i     (duty_p_i),
    .dn_i     (duty_n_i),
    .dx_i     (duty_x_i),
    .demand_o (demand),
    .enable_o (enable)
  );

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    spwm4_deadtime #(.DT_W(DT_W)) u_dt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en_i  (enable),
      .dem_i (demand[g]),
      .dt_i  (dead_i),
      .up_o  (gate_up_o[g]),
      .dn_o  (gate_dn_o[g])
    );
  end

  // R3: invalid captured sector leaves every gate off
  p_off_invalid_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enable |-> (gate_up_o == '0 && gate_dn_o == '0));

  // R9: gates stay off while the internal reset is held
  p_reset_off_r9: assert property (@(posedge clk)
    !rst_int_n |-> (gate_up_o == '0 && gate_dn_o == '0));

endmodule

// File: tb/spwm4_top_bench.sv
module spwm4_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;
  localparam int DW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    sector_i;
  logic [CW-1:0] duty_p_i, duty_n_i, duty_x_i;
  logic [DW-1:0] dead_i;
  logic [3:0]    gate_up_o, gate_dn_o;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  int m_cnt, m_sec, m_dp, m_dn, m_dx;
  int m_lvl[4];
  int m_tmr[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  spwm4_top #(.CNT_W(CW), .DT_W(DW)) u_spwm4_top (
    .clk(clk), .rst_n(rst_n), .sector_i(sector_i),
    .duty_p_i(duty_p_i), .duty_n_i(duty_n_i), .duty_x_i(duty_x_i),
    .dead_i(dead_i), .gate_up_o(gate_up_o), .gate_dn_o(gate_dn_o)
  );

  function automatic int clamp_of(int s);
    case (s)
      0, 3: return 1;
      1, 4: return 0;
      default: return 2;
    endcase
  endfunction

  // R4 R5 R6: expected demand of a leg from captured values
  function automatic int leg_demand(int leg);
    int c, pl;
    if (m_sec > 5) return 0;
    c  = clamp_of(m_sec);
    pl = (c + 1) % 3;
    if (leg == 3)  return (m_cnt < m_dx) ? 1 : 0;
    if (leg == c)  return m_sec % 2;
    if (leg == pl) return (m_cnt < m_dp) ? 1 : 0;
    return (m_cnt < m_dn) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_sec = 7; m_dp = 0; m_dn = 0; m_dx = 0;
    for (int i = 0; i < 4; i++) begin m_lvl[i] = 0; m_tmr[i] = 0; end
  endtask

  // one rising edge of the reference: R1 R2 R7 R8
  task automatic model_advance();
    int d[4];
    for (int i = 0; i < 4; i++) d[i] = leg_demand(i);
    for (int i = 0; i < 4; i++) begin
      if (d[i] != m_lvl[i]) begin m_lvl[i] = d[i]; m_tmr[i] = 0; end
      else if (m_tmr[i] < int'(dead_i)) m_tmr[i]++;
    end
    if (m_cnt == CMAX) begin
      m_cnt = 0; m_sec = int'(sector_i);
      m_dp = int'(duty_p_i); m_dn = int'(duty_n_i); m_dx = int'(duty_x_i);
    end else m_cnt++;
  endtask

  task automatic check_gates();
    bit en, eu, ed;
    string tag;
    en = (m_sec < 6);
    for (int i = 0; i < 4; i++) begin
      eu = en && m_lvl[i] == 1 && m_tmr[i] >= int'(dead_i);
      ed = en && m_lvl[i] == 0 && m_tmr[i] >= int'(dead_i);
      if (!en) tag = "R3";
      else if (i == 3) tag = "R6";
      else if (i == clamp_of(m_sec)) tag = "R4";
      else if (m_tmr[i] < int'(dead_i)) tag = "R7";
      else tag = "R5";
      checks++;
      if (gate_up_o[i] !== eu || gate_dn_o[i] !== ed) begin
        bad++;
        $display("FAIL %s leg%0d t=%0t up/dn=%b%b expected %b%b",
                 tag, i, $time, gate_up_o[i], gate_dn_o[i], eu, ed);
      end
    end
    checks++;
    if ((gate_up_o & gate_dn_o) != 4'b0) begin
      bad++;
      $display("FAIL R7 overlap up=%b dn=%b expected no overlap", gate_up_o, gate_dn_o);
    end
  endtask

  // drive inputs, let the rising edge happen, check at the falling edge
  task automatic step(input int s, input int p, input int n, input int x);
    sector_i = 3'(s); duty_p_i = CW'(p); duty_n_i = CW'(n); duty_x_i = CW'(x);
    model_advance();
    @(negedge clk);
    check_gates();
  endtask

  task automatic hold(input int s, input int p, input int n, input int x, input int cyc);
    for (int k = 0; k < cyc; k++) step(s, p, n, x);
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; sector_i = 3'd0; duty_p_i = '0; duty_n_i = '0; duty_x_i = '0;
    dead_i = 4'd2;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (gate_up_o !== 4'b0 || gate_dn_o !== 4'b0) begin
        bad++; $display("FAIL R9 reset up=%b dn=%b expected 0000/0000", gate_up_o, gate_dn_o);
      end
    end
    rst_n = 1'b1;
    // R9: two synchronizer clocks with gates off, no reference advance
    repeat (2) begin
      @(negedge clk);
      checks++;
      if (gate_up_o !== 4'b0 || gate_dn_o !== 4'b0) begin
        bad++; $display("FAIL R9 release up=%b dn=%b expected 0000/0000", gate_up_o, gate_dn_o);
      end
    end
    // R3: before first wrap everything off even with a valid sector driven
    hold(0, 20, 12, 6, 20);
    // R4 R5 R6: each sector with ordered duties
    for (int s = 0; s < 6; s++) hold(s, 24, 14, 5, 2 * (CMAX + 1));
    // R3: invalid sector codes
    hold(6, 20, 10, 4, 2 * (CMAX + 1));
    hold(7, 20, 10, 4, CMAX + 1);
    // R7: zero dead interval
    dead_i = 4'd0;
    hold(1, 18, 9, 3, 2 * (CMAX + 1));
    // R5 R6: duty extremes
    dead_i = 4'd3;
    hold(2, CMAX, 0, CMAX, 2 * (CMAX + 1));
    hold(5, 0, CMAX, 0, 2 * (CMAX + 1));
    // R2: inputs changing every cycle, only wrap values count
    dead_i = 4'd1;
    for (int k = 0; k < 6000; k++)
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, CMAX)),
           int'($urandom_range(0, CMAX)), int'($urandom_range(0, CMAX)));
    // random per period with varying dead interval
    for (int k = 0; k < 60; k++) begin
      dead_i = DW'($urandom_range(0, 6));
      hold(int'($urandom_range(0, 5)), int'($urandom_range(16, CMAX)),
           int'($urandom_range(6, 15)), int'($urandom_range(0, 5)), CMAX + 1);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule